// File: doc/BRIEF.md
# Radix-B Sign-Magnitude Adder-Subtractor

This combinational block adds or subtracts two signed numbers held in sign-magnitude form. Each operand is a sign bit plus a magnitude of `MAG_DIGITS` radix-`RADIX` digits. The result is a sign bit plus a magnitude one digit wider than an operand magnitude, so any sum or difference fits and no overflow case exists. A select input picks the operation. Subtraction is done by flipping the sign of the second operand before anything else happens.

Inside, the block first decides whether the magnitudes are really added or really subtracted. This effective-subtract decision is the XOR of the first sign and the adjusted second sign. A first digit adder then either adds the two magnitudes, or adds the first magnitude to the digit-wise complement of the second with a carry-in of one. If the leading digit of that intermediate is at least half the radix, the intermediate is a negative complement. A second digit adder then re-complements it and adds one. The output sign is the first sign when no fix-up was needed, and the adjusted second sign when it was. The block has no clock, no reset and no state. The house state-machine layout does not apply here, so the design is a fixed two-stage datapath.

Top module: `smadd_top`

## Requirements
- R1: With `sub_sel` = 0 the result equals x + y. With `sub_sel` = 1 it equals x − y, done by treating the sign of y as `y_sign` XOR 1.
- R2: When `x_sign` equals the adjusted sign of y (no effective subtraction), the result magnitude is the sum of the two magnitudes and `z_sign` equals `x_sign`.
- R3: Under effective subtraction with |x| > |y|, the result magnitude is |x| − |y| and `z_sign` equals `x_sign`.
- R4: Under effective subtraction with |y| > |x|, the intermediate's leading digit is at least RADIX/2. It is re-complemented to give |y| − |x|, and `z_sign` equals the adjusted sign of y.
- R5: Under effective subtraction with equal magnitudes, `z_mag` is zero and `z_sign` equals `x_sign`.
- R6: Every magnitude is a vector of digits. Digit i occupies bits [i·DW +: DW] as an unsigned binary value, with DW = clog2(RADIX). Every output digit is below RADIX whenever every input digit is.
- R7: The result always fits in MAG_DIGITS+1 digits. Its leading digit is 0 or 1, and no carry leaves the second adder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_sign | input | 1 | Sign of x (1 = negative) |
| x_mag | input | MAG_DIGITS·DW | Magnitude digits of x, least significant digit in the low bits |
| y_sign | input | 1 | Sign of y (1 = negative) |
| y_mag | input | MAG_DIGITS·DW | Magnitude digits of y |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| z_sign | output | 1 | Sign of the result |
| z_mag | output | (MAG_DIGITS+1)·DW | Magnitude digits of the result |

## Verification
The immediate assertions check on every input change several properties. An effective addition never sets the negative flag and never carries out of the first adder. An effective subtraction with |x| ≥ |y| never sets the negative flag. Equal magnitudes under effective subtraction give a zero result signed like x. Every output digit stays within the radix and the leading digit stays at 0 or 1. Only the bench's sweeps can show that the numeric value and the sign match signed-integer arithmetic for each combination of signs, operation and magnitude ordering. The sweeps cover every operand pair at two small radices, which includes zero, the largest magnitude and equal magnitudes.

// File: rtl/smadd_pkg.sv
package smadd_pkg;

    // Bits needed to hold one digit of the given radix.
    function automatic int unsigned digit_bits(input int unsigned radix);
        return $clog2(radix);
    endfunction

endpackage

// File: rtl/smadd_digit_cmpl.sv
// Optional digit-wise (RADIX-1)'s complement over NDIG digits.
module smadd_digit_cmpl #(
    parameter int unsigned RADIX = 10,
    parameter int unsigned NDIG  = 4,
    parameter int unsigned DW    = smadd_pkg::digit_bits(RADIX)
) (
    input  logic                en,
    input  logic [NDIG*DW-1:0]  d,
    output logic [NDIG*DW-1:0]  q
);
    localparam logic [DW-1:0] TOP_DIGIT = DW'(RADIX - 1);

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        assign q[i*DW +: DW] = en ? (TOP_DIGIT - d[i*DW +: DW]) : d[i*DW +: DW];
    end
endmodule

// File: rtl/smadd_digit_adder.sv
// Ripple-carry radix-RADIX adder over NDIG digits.
module smadd_digit_adder #(
    parameter int unsigned RADIX = 10,
    parameter int unsigned NDIG  = 4,
    parameter int unsigned DW    = smadd_pkg::digit_bits(RADIX)
) (
    input  logic [NDIG*DW-1:0]  a,
    input  logic [NDIG*DW-1:0]  b,
    input  logic                cin,
    output logic [NDIG*DW-1:0]  sum,
    output logic                cout
);
    localparam logic [DW:0] RAD = (DW+1)'(RADIX);

    logic [NDIG:0] carry;
    assign carry[0] = cin;

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        logic [DW:0] tot;
        logic        wrap;
        assign tot  = {1'b0, a[i*DW +: DW]} + {1'b0, b[i*DW +: DW]}
                    + {{DW{1'b0}}, carry[i]};
        assign wrap = (tot >= RAD);
        assign sum[i*DW +: DW] = wrap ? DW'(tot - RAD) : tot[DW-1:0];
        assign carry[i+1]      = wrap;
    end

    assign cout = carry[NDIG];
endmodule

// File: rtl/smadd_top.sv
// Sign-magnitude adder-subtractor, radix RADIX, two cascaded digit adders.
module smadd_top #(
    parameter int unsigned RADIX      = 10,
    parameter int unsigned MAG_DIGITS = 3,
    parameter int unsigned DW         = smadd_pkg::digit_bits(RADIX)
) (
    input  logic                         x_sign,
    input  logic [MAG_DIGITS*DW-1:0]     x_mag,
    input  logic                         y_sign,
    input  logic [MAG_DIGITS*DW-1:0]     y_mag,
    input  logic                         sub_sel,
    output logic                         z_sign,
    output logic [(MAG_DIGITS+1)*DW-1:0] z_mag
);
    localparam int unsigned ND   = MAG_DIGITS + 1;
    localparam int unsigned W    = ND * DW;
    localparam logic [DW-1:0] HALF  = DW'(RADIX / 2);
    localparam logic [DW-1:0] LIMIT = DW'(RADIX - 1);

    if (RADIX < 4) begin : g_bad_radix
        $error("smadd_top needs RADIX of at least 4");
    end

    // Effective operation
    logic y_sign_eff, eff_sub;
    assign y_sign_eff = y_sign ^ sub_sel;
    assign eff_sub    = x_sign ^ y_sign_eff;

    // Stage 1: x + y or x + complement(y) + 1, one extra leading digit
    logic [W-1:0] x_ext, y_ext, y_sel, inter;
    logic         cout1;
    assign x_ext = {{DW{1'b0}}, x_mag};
    assign y_ext = {{DW{1'b0}}, y_mag};

    smadd_digit_cmpl #(.RADIX(RADIX), .NDIG(ND), .DW(DW)) u_cmpl_y (
        .en(eff_sub), .d(y_ext), .q(y_sel)
    );

    smadd_digit_adder #(.RADIX(RADIX), .NDIG(ND), .DW(DW)) u_add_1 (
        .a(x_ext), .b(y_sel), .cin(eff_sub), .sum(inter), .cout(cout1)
    );

    // Stage 2: re-complement a negative intermediate
    logic         neg, cout2;
    logic [W-1:0] inter_c;
    assign neg = (inter[W-1 -: DW] >= HALF);

    smadd_digit_cmpl #(.RADIX(RADIX), .NDIG(ND), .DW(DW)) u_cmpl_a (
        .en(neg), .d(inter), .q(inter_c)
    );

    smadd_digit_adder #(.RADIX(RADIX), .NDIG(ND), .DW(DW)) u_add_2 (
        .a(inter_c), .b({W{1'b0}}), .cin(neg), .sum(z_mag), .cout(cout2)
    );

    assign z_sign = neg ? y_sign_eff : x_sign;

    // Checks next to the datapath (only meaningful for legal input digits)
    logic in_legal;
    always_comb begin
        in_legal = 1'b1;
        for (int i = 0; i < int'(MAG_DIGITS); i++) begin
            if (x_mag[i*DW +: DW] > LIMIT) in_legal = 1'b0;
            if (y_mag[i*DW +: DW] > LIMIT) in_legal = 1'b0;
        end
    end

    always_comb begin
        if (in_legal) begin
            // R2: an effective addition is never negative and never carries out
            a_r2_add_nonneg: assert (eff_sub || (!neg && !cout1))
                else $error("effective add flagged negative or overflowed");
            // R3: |x| >= |y| under subtraction needs no fix-up
            a_r3_no_fixup: assert (!(eff_sub && (x_mag >= y_mag)) || !neg)
                else $error("fix-up taken with |x| >= |y|");
            // R5: equal magnitudes give zero signed like x
            a_r5_zero_sign: assert (!(eff_sub && (x_mag == y_mag))
                                    || (z_mag == '0 && z_sign == x_sign))
                else $error("equal magnitudes did not give signed zero");
            // R7: result fits, leading digit 0 or 1, no final carry
            a_r7_no_overflow: assert (!cout2 && (z_mag[W-1 -: DW] <= DW'(1)))
                else $error("result does not fit");
            for (int i = 0; i < int'(ND); i++) begin
                // R6: digits stay inside the radix
                a_r6_digit_range: assert (z_mag[i*DW +: DW] <= LIMIT)
                    else $error("output digit out of range");
            end
        end
    end
endmodule

// File: tb/sim_smadd_top.sv
`timescale 1ns/1ps
module sim_smadd_top;

    // Unit 0: radix 5, two magnitude digits
    localparam int R0 = 5, M0 = 2, D0 = 3;
    // Unit 1: radix 4, three magnitude digits
    localparam int R1X = 4, M1 = 3, D1 = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic              xs0, ys0, op0, zs0;
    logic [M0*D0-1:0]  xm0, ym0;
    logic [(M0+1)*D0-1:0] zm0;
    logic              xs1, ys1, op1, zs1;
    logic [M1*D1-1:0]  xm1, ym1;
    logic [(M1+1)*D1-1:0] zm1;

    smadd_top #(.RADIX(R0), .MAG_DIGITS(M0)) u0 (
        .x_sign(xs0), .x_mag(xm0), .y_sign(ys0), .y_mag(ym0),
        .sub_sel(op0), .z_sign(zs0), .z_mag(zm0)
    );
    smadd_top #(.RADIX(R1X), .MAG_DIGITS(M1)) u1 (
        .x_sign(xs1), .x_mag(xm1), .y_sign(ys1), .y_mag(ym1),
        .sub_sel(op1), .z_sign(zs1), .z_mag(zm1)
    );

    function automatic logic [31:0] to_digits(int v, int radix, int dw, int nd);
        logic [31:0] r = '0;
        int t = v;
        for (int i = 0; i < nd; i++) begin
            r = r | (32'(t % radix) << (i*dw));
            t = t / radix;
        end
        return r;
    endfunction

    function automatic int digit_at(logic [31:0] v, int dw, int i);
        return int'((v >> (i*dw)) & ((32'd1 << dw) - 1));
    endfunction

    task automatic judge(int sx, int mx, int sy, int my, int op,
                         int zs, logic [31:0] zm, int radix, int dw, int nd);
        int vx, vy, vr, emag, esign, val, maxd, top, eff;
        string tag;
        vx = sx ? -mx : mx;
        vy = sy ? -my : my;
        vr = op ? vx - vy : vx + vy;
        emag = vr < 0 ? -vr : vr;
        esign = vr < 0 ? 1 : (vr > 0 ? 0 : sx);
        eff = sx ^ (sy ^ op);
        if (!eff)          tag = "R2";
        else if (mx > my)  tag = "R3";
        else if (mx < my)  tag = "R4";
        else               tag = "R5";
        if (op) tag = {"R1/", tag};
        val = 0; maxd = 0;
        for (int i = nd - 1; i >= 0; i--) begin
            val = val * radix + digit_at(zm, dw, i);
            if (digit_at(zm, dw, i) > maxd) maxd = digit_at(zm, dw, i);
        end
        top = digit_at(zm, dw, nd - 1);
        checks++;
        if (val != emag || maxd >= radix) begin
            failures++;
            $display("FAIL %s magnitude x=%0d%0d y=%0d%0d op=%0d: actual %0d expected %0d",
                     tag, sx, mx, sy, my, op, val, emag);
        end
        checks++;
        if (zs != esign) begin
            failures++;
            $display("FAIL %s sign x=%0d%0d y=%0d%0d op=%0d: actual %0d expected %0d",
                     tag, sx, mx, sy, my, op, zs, esign);
        end
        checks++; // R6 digit range
        if (maxd >= radix) begin
            failures++;
            $display("FAIL R6 digit range: actual max %0d expected below %0d", maxd, radix);
        end
        checks++; // R7 leading digit
        if (top > 1) begin
            failures++;
            $display("FAIL R7 leading digit: actual %0d expected at most 1", top);
        end
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                failures++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin : stim
        int lim0, lim1;
        xs0 = 0; ys0 = 0; op0 = 0; xm0 = '0; ym0 = '0;
        xs1 = 0; ys1 = 0; op1 = 0; xm1 = '0; ym1 = '0;
        lim0 = R0 ** M0;
        lim1 = R1X ** M1;
        #3;
        // Full sweep, unit 0 (covers zero, largest magnitude, equal magnitudes)
        for (int c = 0; c < 8; c++) begin
            for (int a = 0; a < lim0; a++) begin
                for (int b = 0; b < lim0; b++) begin
                    xs0 = c[0]; ys0 = c[1]; op0 = c[2];
                    xm0 = (M0*D0)'(to_digits(a, R0, D0, M0));
                    ym0 = (M0*D0)'(to_digits(b, R0, D0, M0));
                    #1;
                    judge(c[0], a, c[1], b, c[2], int'(zs0), 32'(zm0), R0, D0, M0+1);
                    #1;
                end
            end
        end
        // Full sweep, unit 1
        for (int c = 0; c < 8; c++) begin
            for (int a = 0; a < lim1; a++) begin
                for (int b = 0; b < lim1; b++) begin
                    xs1 = c[0]; ys1 = c[1]; op1 = c[2];
                    xm1 = (M1*D1)'(to_digits(a, R1X, D1, M1));
                    ym1 = (M1*D1)'(to_digits(b, R1X, D1, M1));
                    #1;
                    judge(c[0], a, c[1], b, c[2], int'(zs1), 32'(zm1), R1X, D1, M1+1);
                    #1;
                end
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule